// File: doc/BRIEF.md
# Multiplexed Bus Memory-Map Decoder

This block sits on the external bus of an 8-bit microcontroller whose port carries the low address byte and the data on the same pins. While the address strobe `ale` is high the block tracks the shared port into a holding register. When `ale` falls, that register freezes the low address byte for the rest of the bus cycle. The block joins the frozen byte to the separately driven high address byte and presents the full 16-bit address to the memories. It does this in registered form, and the low byte lines can be permuted.

From the high address byte the block decodes one of three regions in the 64 KB space. These are a 32 KB RAM region, a flash region that ends 2 KB short of the top, and a top 2 KB split into eight 256-byte peripheral windows. For each region it drives an active-low chip select. It also produces a memory read strobe that answers both data reads and program fetches, and a write strobe that is blocked while a fetch is in progress. Every output is registered on `clk`, so each one reflects the inputs sampled at the previous rising edge.

Top module: `mbus_map_decoder`

## Requirements
- R1: `ram_sel_n` is low exactly when address bit 15 is 0 (0x0000 to 0x7FFF).
- R2: `flash_sel_n` is low exactly when bit 15 is 1 and at least one of bits 14..11 is 0 (0x8000 to 0xF7FF).
- R3: When bits 15..11 are all 1 (0xF800 to 0xFFFF), `periph_sel_n[k]` is low for the single k equal to bits 10..8, so each window spans 256 bytes.
- R4: For every address exactly one of the ten selects is low after decoding, and never more than one is low.
- R5: The selects settle one clock after `addr_hi` is sampled and depend on nothing else: not the low byte, not `ale`, and not the strobes.
- R6: The latched low byte follows `ad_in` at each edge where `ale` is high, and holds unchanged at every edge where `ale` is low.
- R7: `mem_addr[15:8]` is `addr_hi` registered. `mem_addr[j]` for j in 0..7 is latched bit `LO_PERM[3j+2:3j]`. The default permutation is the identity, so `mem_addr[7:0]` equals the latched byte.
- R8: `mem_rd_n` is low one clock after `rd_n` or `fetch_n` is low, and is high otherwise.
- R9: `mem_wr_n` is low one clock after `wr_n` is low while `fetch_n` is high. It stays high whenever `fetch_n` is low.
- R10: A clock edge with `rst` high forces all selects and both strobes high and clears `mem_addr` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; low byte is tracked while high |
| ad_in | input | 8 | Multiplexed low address / data port |
| addr_hi | input | 8 | High address byte |
| rd_n | input | 1 | Data read request, active low |
| wr_n | input | 1 | Write request, active low |
| fetch_n | input | 1 | Program fetch request, active low |
| mem_addr | output | 16 | Registered address to memories |
| ram_sel_n | output | 1 | RAM select, active low |
| flash_sel_n | output | 1 | Flash select, active low |
| periph_sel_n | output | 8 | Peripheral window selects, active low |
| mem_rd_n | output | 1 | Qualified read strobe, active low |
| mem_wr_n | output | 1 | Qualified write strobe, active low |

## Verification
The properties assume that `addr_hi`, `ale` and the three request strobes are synchronous to `clk` and stable around each rising edge. They also assume that `rst` is held for at least one edge before any result is judged. The bench respects these assumptions by changing every input only on the falling clock edge and by sampling results on the following falling edge. The walk over all 65536 addresses keeps `ale` high, so the latched byte always belongs to the address under test. The hold behaviour is exercised separately by pulling `ale` low and then disturbing `ad_in`.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  typedef enum logic [1:0] {
    REGION_RAM    = 2'd0,
    REGION_FLASH  = 2'd1,
    REGION_PERIPH = 2'd2
  } region_e;

  // Region from the top bit and the "all middle bits set" term.
  function automatic region_e classify(input logic top_bit, input logic mid_all_ones);
    if (!top_bit)          return REGION_RAM;
    else if (!mid_all_ones) return REGION_FLASH;
    else                   return REGION_PERIPH;
  endfunction

endpackage

// File: rtl/mbd_addr_capture.sv
module mbd_addr_capture #(
  parameter int HI_W = 8,
  parameter int LO_W = 8,
  parameter int IDX_W = 3,
  parameter logic [LO_W*IDX_W-1:0] LO_PERM = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad_in,
  input  logic [HI_W-1:0]      addr_hi,
  output logic [HI_W+LO_W-1:0] addr_out
);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_pins;

  // Low byte follows the port while the strobe is high, freezes once it drops.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      hi_q <= addr_hi;
      if (ale) lo_q <= ad_in;
    end
  end

  // Board-level line swap: pin j is driven from latched bit LO_PERM[j].
  for (genvar j = 0; j < LO_W; j++) begin : g_perm
    assign lo_pins[j] = lo_q[LO_PERM[j*IDX_W +: IDX_W]];
  end

  assign addr_out = {hi_q, lo_pins};

endmodule

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
  import mbd_pkg::*;
#(
  parameter int HI_W   = 8,
  parameter int PSEL_W = 3,
  localparam int PERIPH_N = 1 << PSEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [HI_W-1:0]     addr_hi,
  output logic                ram_sel_n,
  output logic                flash_sel_n,
  output logic [PERIPH_N-1:0] periph_sel_n
);

  logic                top_bit;
  logic                mid_all_ones;
  logic                mid_nand;
  region_e             region;
  logic                periph_en;
  logic [PERIPH_N-1:0] periph_hit;

  assign top_bit      = addr_hi[HI_W-1];
  assign mid_all_ones = &addr_hi[HI_W-2:PSEL_W];
  assign mid_nand     = ~mid_all_ones;
  assign region       = classify(top_bit, mid_all_ones);
  assign periph_en    = top_bit & ~mid_nand;

  // One comparator per window against the low bits of the high byte.
  for (genvar k = 0; k < PERIPH_N; k++) begin : g_win
    assign periph_hit[k] = periph_en && (addr_hi[PSEL_W-1:0] == PSEL_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel_n    <= 1'b1;
      flash_sel_n  <= 1'b1;
      periph_sel_n <= '1;
    end else begin
      ram_sel_n    <= (region != REGION_RAM);
      flash_sel_n  <= (region != REGION_FLASH);
      periph_sel_n <= ~periph_hit;
    end
  end

endmodule

// File: rtl/mbd_strobe_qual.sv
module mbd_strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic wr_n,
  input  logic fetch_n,
  output logic mem_rd_n,
  output logic mem_wr_n
);

  logic rd_any_n;
  logic wr_ok_n;

  assign rd_any_n = rd_n & fetch_n;
  assign wr_ok_n  = wr_n | ~fetch_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_n <= 1'b1;
      mem_wr_n <= 1'b1;
    end else begin
      mem_rd_n <= rd_any_n;
      mem_wr_n <= wr_ok_n;
    end
  end

endmodule

// File: rtl/mbus_map_decoder.sv
module mbus_map_decoder #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int PSEL_W = 3,
  parameter logic [LO_W*$clog2(LO_W)-1:0] LO_PERM =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ale,
  input  logic [LO_W-1:0]          ad_in,
  input  logic [HI_W-1:0]          addr_hi,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic                     fetch_n,
  output logic [HI_W+LO_W-1:0]     mem_addr,
  output logic                     ram_sel_n,
  output logic                     flash_sel_n,
  output logic [(1<<PSEL_W)-1:0]   periph_sel_n,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n
);

  localparam int IDX_W = $clog2(LO_W);

  mbd_addr_capture #(
    .HI_W(HI_W), .LO_W(LO_W), .IDX_W(IDX_W), .LO_PERM(LO_PERM)
  ) u_capture (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in),
    .addr_hi(addr_hi), .addr_out(mem_addr)
  );

  mbd_region_decode #(
    .HI_W(HI_W), .PSEL_W(PSEL_W)
  ) u_decode (
    .clk(clk), .rst(rst), .addr_hi(addr_hi),
    .ram_sel_n(ram_sel_n), .flash_sel_n(flash_sel_n),
    .periph_sel_n(periph_sel_n)
  );

  mbd_strobe_qual u_strobe (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

endmodule

// File: rtl/mbus_map_decoder_chk.sv
module mbus_map_decoder_chk #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 8,
  parameter int PSEL_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ale,
  input logic [HI_W-1:0]        addr_hi,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic                   fetch_n,
  input logic [HI_W+LO_W-1:0]   mem_addr,
  input logic                   ram_sel_n,
  input logic                   flash_sel_n,
  input logic [(1<<PSEL_W)-1:0] periph_sel_n,
  input logic                   mem_rd_n,
  input logic                   mem_wr_n
);

  logic [(1<<PSEL_W)+1:0] active;
  assign active = {~ram_sel_n, ~flash_sel_n, ~periph_sel_n};

  assert_one_select_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active));

  assert_ram_follows_top_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ram_sel_n == $past(addr_hi[HI_W-1])));

  assert_low_byte_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ale) |=> $stable(mem_addr[LO_W-1:0]));

  assert_read_qual_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !fetch_n) |=> !mem_rd_n);

  assert_no_write_in_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    !fetch_n |=> mem_wr_n);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (ram_sel_n && flash_sel_n && (&periph_sel_n) && mem_rd_n && mem_wr_n
             && (mem_addr == '0)));

endmodule

bind mbus_map_decoder mbus_map_decoder_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .PSEL_W(PSEL_W)
) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .addr_hi(addr_hi),
  .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n), .mem_addr(mem_addr),
  .ram_sel_n(ram_sel_n), .flash_sel_n(flash_sel_n),
  .periph_sel_n(periph_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
);

// File: tb/mbus_map_decoder_tb_top.sv
module mbus_map_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = 8'h00;
  logic [7:0]  addr_hi = 8'h00;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        fetch_n = 1'b1;
  logic [15:0] mem_addr;
  logic        ram_sel_n;
  logic        flash_sel_n;
  logic [7:0]  periph_sel_n;
  logic        mem_rd_n;
  logic        mem_wr_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  mbus_map_decoder dut_i (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .addr_hi(addr_hi),
    .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n), .mem_addr(mem_addr),
    .ram_sel_n(ram_sel_n), .flash_sel_n(flash_sel_n),
    .periph_sel_n(periph_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  // Table entries: {address, ram hit, flash hit, peripheral hits[7:0]} (active high).
  localparam logic [25:0] VEC [14] = '{
    {16'h0000, 2'b10, 8'b00000000},
    {16'h7FFF, 2'b10, 8'b00000000},
    {16'h7800, 2'b10, 8'b00000000},
    {16'h8000, 2'b01, 8'b00000000},
    {16'hB800, 2'b01, 8'b00000000},
    {16'hF000, 2'b01, 8'b00000000},
    {16'hF7FF, 2'b01, 8'b00000000},
    {16'hF800, 2'b00, 8'b00000001},
    {16'hF9A5, 2'b00, 8'b00000010},
    {16'hFAFF, 2'b00, 8'b00000100},
    {16'hFB00, 2'b00, 8'b00001000},
    {16'hFC10, 2'b00, 8'b00010000},
    {16'hFD80, 2'b00, 8'b00100000},
    {16'hFFFF, 2'b00, 8'b10000000}
  };

  function automatic logic [9:0] expect_hits(input logic [15:0] a);
    logic [9:0] h;
    h = '0;
    if (!a[15])                     h[9] = 1'b1;
    else if (a[14:11] != 4'hF)      h[8] = 1'b1;
    else                            h[a[10:8]] = 1'b1;
    return h;
  endfunction

  function automatic logic [9:0] actual_hits();
    return {~ram_sel_n, ~flash_sel_n, ~periph_sel_n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_addr(input logic [15:0] a);
    addr_hi = a[15:8];
    ad_in   = a[7:0];
    ale     = 1'b1;
    step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      summary();
    end
  end

  initial begin
    @(negedge clk);
    step();
    // R10: reset state
    check("R10 selects", {22'd0, actual_hits()}, 32'd0);
    check("R10 mem_addr", {16'd0, mem_addr}, 32'd0);
    check("R10 strobes", {30'd0, mem_rd_n, mem_wr_n}, 32'd3);
    rst = 1'b0;

    // R1 R2 R3: table walk
    foreach (VEC[i]) begin
      put_addr(VEC[i][25:10]);
      check("R1/R2/R3 table", {22'd0, actual_hits()}, {22'd0, VEC[i][9:0]});
      check("R7 table addr", {16'd0, mem_addr}, {16'd0, VEC[i][25:10]});
    end

    // R4 R5 R7: full sweep, one address per cycle
    for (int a = 0; a < 65536; a++) begin
      put_addr(16'(a));
      check("R4 one select", {22'd0, actual_hits()}, {22'd0, expect_hits(16'(a))});
      check("R7 mem_addr", {16'd0, mem_addr}, a);
    end

    // R6: hold while ale low, then track again
    put_addr(16'h125A);
    ale = 1'b0;
    ad_in = 8'hC3;
    step(); step(); step();
    check("R6 hold", {16'd0, mem_addr}, 32'h125A);
    ale = 1'b1;
    step();
    check("R6 track", {16'd0, mem_addr}, 32'h12C3);
    ale = 1'b0;

    // R5 R8 R9: strobe qualification with fixed address
    addr_hi = 8'hFE;
    rd_n = 1'b0; wr_n = 1'b1; fetch_n = 1'b1;
    step();
    check("R8 data read", {30'd0, mem_rd_n, mem_wr_n}, 32'd1);
    check("R5 select unchanged by strobes", {22'd0, actual_hits()}, {22'd0, expect_hits(16'hFE00)});
    rd_n = 1'b1; wr_n = 1'b0; fetch_n = 1'b0;
    step();
    check("R9 write blocked in fetch", {30'd0, mem_rd_n, mem_wr_n}, 32'd1);
    wr_n = 1'b0; fetch_n = 1'b1;
    step();
    check("R9 write", {30'd0, mem_rd_n, mem_wr_n}, 32'd2);
    wr_n = 1'b1;
    step();
    check("R8 idle", {30'd0, mem_rd_n, mem_wr_n}, 32'd3);
    check("R3 window 6 held", {22'd0, actual_hits()}, 32'h040);

    // R10: reset in the middle of a busy cycle
    addr_hi = 8'h00; ad_in = 8'h77; ale = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
    step();
    rst = 1'b1;
    step();
    check("R10 mid selects", {22'd0, actual_hits()}, 32'd0);
    check("R10 mid mem_addr", {16'd0, mem_addr}, 32'd0);
    check("R10 mid strobes", {30'd0, mem_rd_n, mem_wr_n}, 32'd3);
    rst = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    step();
    check("R1 after reset", {22'd0, actual_hits()}, 32'h200);

    summary();
  end

endmodule